// File: doc/BRIEF.md
# Serial EEPROM Target Model

This block models a serial EEPROM as seen from a byte-level two-wire bus target port. The host side of the port presents four kinds of operation, one per clock cycle: a start carrying a 7-bit device address and a direction flag, a written byte that the block acknowledges or refuses, a read byte, and a stop. Behind the port sits a byte array whose size is a power-of-two parameter. A preload port writes the array directly so a test or boot sequence can fill it without going through the bus.

The word-address width follows the array size: arrays below 4096 bytes take a single address byte, larger ones take two. When the array holds more bytes than the word address can reach, the low bits of the device address pick the upper array bits. The block then answers a run of consecutive device addresses instead of one. After the address bytes, each data byte is written (when the write-enable input allows) or read at the pointer, and the pointer steps forward, wrapping at the end of the array.

Top module: `serial_eeprom_target`

## Requirements
- R1: The word address is 8 bits when MEM_BYTES is below 4096 and 16 bits otherwise; address bits above the array size are dropped, and when the array is larger than the word address reaches, the device-address low bits of the current transfer fill the pointer bits above the word address.
- R2: With DEV_LOW = log2(MEM_BYTES) minus the word-address width (0 if negative), `start_ack` is high in a start cycle exactly when the device address lies in the 2^DEV_LOW consecutive addresses starting at DEV_ADDR with its DEV_LOW low bits cleared; a start to any other address is refused and ends any open transfer.
- R3: A matching start while no transfer is open loads the pointer with the device-address low bits placed just above the word address, all other pointer bits zero.
- R4: In a write-direction transfer the first one (8-bit) or two (16-bit, high byte first) written bytes after a start form the word address.
- R5: Each written byte after the address bytes is stored at the pointer only while `write_en` is 1; it is acknowledged and the pointer advances whether stored or not.
- R6: A read byte places the array byte at the pointer on `rd_data` in the cycle after `rd_valid`, then advances the pointer; `rd_data` is 0 after reset.
- R7: Advancing the pointer from the last array location gives location 0.
- R8: A matching start while a transfer is open restarts the address bytes but keeps the pointer.
- R9: A written byte in a read-direction transfer is refused (`wr_ack` low) and changes neither the pointer nor the array.
- R10: After a stop, or outside any transfer, written bytes are refused and read bytes leave `rd_data` and the pointer unchanged.
- R11: A preload write in the same cycle as a bus write to the same location leaves the bus value; a bus read in the same cycle as a preload write to its location returns the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| write_en | input | 1 | Allows data bytes to be stored |
| start_valid | input | 1 | Start (or repeated start) operation this cycle |
| start_dev_addr | input | 7 | Device address of the start |
| start_read | input | 1 | Direction of the start, 1 = read |
| start_ack | output | 1 | Start accepted (combinational) |
| wr_valid | input | 1 | Write-byte operation this cycle |
| wr_data | input | 8 | Byte written |
| wr_ack | output | 1 | Written byte acknowledged (combinational) |
| rd_valid | input | 1 | Read-byte operation this cycle |
| rd_data | output | 8 | Byte read, valid the cycle after rd_valid |
| stop_valid | input | 1 | Stop operation this cycle |
| bd_we | input | 1 | Preload write strobe |
| bd_addr | input | AW | Preload array location |
| bd_data | input | 8 | Preload byte |

## Verification
The preload port and the bus data path can touch the same array location in one cycle, either as two writes or as a bus read against a preload write. The bench raises the preload strobe in the very cycle that a bus data byte or read byte is presented at that location, then re-addresses the location over the bus. It judges that the bus byte survives the double write and that the colliding read returned the value held before the preload.

// File: rtl/eeprom_tgt_pkg.sv
package eeprom_tgt_pkg;

   localparam int SHORT_WA_LIMIT = 4096;
   localparam int MAX_ADDR_BITS  = 23;

   function automatic int word_addr_bits(input int bytes);
      return (bytes < SHORT_WA_LIMIT) ? 8 : 16;
   endfunction

   // device address placed above the word address
   function automatic logic [23:0] dev_field(input logic [6:0] dev, input int wa);
      return {17'd0, dev} << wa;
   endfunction

   // shift one address byte into the pointer, keep wa bits, add device bits
   function automatic logic [23:0] shift_addr(input logic [23:0] cur,
                                              input logic [7:0]  b,
                                              input logic [6:0]  dev,
                                              input int          wa);
      logic [23:0] keep;
      keep = (24'd1 << wa) - 24'd1;
      return (((cur << 8) | {16'd0, b}) & keep) | dev_field(dev, wa);
   endfunction

endpackage

// File: rtl/eeprom_tgt_decode.sv
module eeprom_tgt_decode #(
   parameter int         AW       = 9,
   parameter int         WA       = 8,
   parameter logic [6:0] DEV_ADDR = 7'h51
) (
   input  logic [6:0] dev,
   output logic       hit
);
   localparam int DEV_LOW = (AW > WA) ? (AW - WA) : 0;

   assign hit = (((dev ^ DEV_ADDR) >> DEV_LOW) == 7'd0);

endmodule

// File: rtl/eeprom_tgt_ptr.sv
module eeprom_tgt_ptr
   import eeprom_tgt_pkg::*;
#(
   parameter int AW = 9,
   parameter int WA = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_hit,
   input  logic          start_miss,
   input  logic          start_read,
   input  logic [6:0]    start_dev,
   input  logic          stop,
   input  logic          wr,
   input  logic [7:0]    wr_data,
   input  logic          rd,
   output logic [AW-1:0] ptr_q,
   output logic          active_q,
   output logic          rd_dir_q,
   output logic          wr_take,
   output logic          data_phase,
   output logic          rd_take
);
   localparam logic [AW-1:0] LAST = '1;

   logic [1:0]    acnt_q;
   logic [6:0]    dev_q;
   logic          addr_phase;
   logic [AW-1:0] ptr_next;
   logic [AW-1:0] preload;
   logic [AW-1:0] loaded;

   generate
      if (WA == 8) begin : g_one_addr_byte
         assign addr_phase = (acnt_q == 2'd0);
      end else begin : g_two_addr_bytes
         assign addr_phase = (acnt_q != 2'd2);
      end
   endgenerate

   assign wr_take    = wr & active_q & ~rd_dir_q;
   assign rd_take    = rd & active_q;
   assign data_phase = ~addr_phase;
   assign ptr_next   = (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
   assign preload    = AW'(dev_field(start_dev, WA));
   assign loaded     = AW'(shift_addr(24'(ptr_q), wr_data, dev_q, WA));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         rd_dir_q <= 1'b0;
         acnt_q   <= 2'd0;
         dev_q    <= 7'd0;
         ptr_q    <= '0;
      end else if (start_hit) begin
         active_q <= 1'b1;
         rd_dir_q <= start_read;
         acnt_q   <= 2'd0;
         dev_q    <= start_dev;
         if (!active_q) ptr_q <= preload;
      end else if (start_miss || stop) begin
         active_q <= 1'b0;
      end else if (wr_take) begin
         if (addr_phase) begin
            ptr_q  <= loaded;
            acnt_q <= acnt_q + 2'd1;
         end else begin
            ptr_q <= ptr_next;
         end
      end else if (rd_take) begin
         ptr_q <= ptr_next;
      end
   end

endmodule

// File: rtl/eeprom_tgt_mem.sv
module eeprom_tgt_mem #(
   parameter int AW = 9
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          bd_we,
   input  logic [AW-1:0] bd_addr,
   input  logic [7:0]    bd_data,
   input  logic          bus_we,
   input  logic [AW-1:0] bus_addr,
   input  logic [7:0]    bus_data,
   input  logic          rd_en,
   input  logic [AW-1:0] rd_addr,
   output logic [7:0]    rd_q
);
   localparam int DEPTH = 1 << AW;

   logic [7:0] cells [DEPTH];

   // bus write is applied last so it wins a same-location collision
   always_ff @(posedge clk) begin
      if (bd_we)  cells[bd_addr]  <= bd_data;
      if (bus_we) cells[bus_addr] <= bus_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rd_q <= 8'd0;
      else if (rd_en) rd_q <= cells[rd_addr];
   end

endmodule

// File: rtl/serial_eeprom_target.sv
module serial_eeprom_target
   import eeprom_tgt_pkg::*;
#(
   parameter int         MEM_BYTES = 512,
   parameter logic [6:0] DEV_ADDR  = 7'h51,
   localparam int        AW        = $clog2(MEM_BYTES)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          write_en,
   input  logic          start_valid,
   input  logic [6:0]    start_dev_addr,
   input  logic          start_read,
   output logic          start_ack,
   input  logic          wr_valid,
   input  logic [7:0]    wr_data,
   output logic          wr_ack,
   input  logic          rd_valid,
   output logic [7:0]    rd_data,
   input  logic          stop_valid,
   input  logic          bd_we,
   input  logic [AW-1:0] bd_addr,
   input  logic [7:0]    bd_data
);
   localparam int WA = word_addr_bits(MEM_BYTES);

   generate
      if (MEM_BYTES < 2 || (MEM_BYTES & (MEM_BYTES - 1)) != 0) begin : g_bad_size
         $error("MEM_BYTES must be a power of two of at least 2");
      end
      if (AW > MAX_ADDR_BITS) begin : g_too_large
         $error("MEM_BYTES exceeds the 23-bit array address limit");
      end
   endgenerate

   logic          dev_hit;
   logic [AW-1:0] ptr_q;
   logic          active_q;
   logic          rd_dir_q;
   logic          wr_take;
   logic          data_phase;
   logic          rd_take;
   logic          bus_we;

   eeprom_tgt_decode #(.AW(AW), .WA(WA), .DEV_ADDR(DEV_ADDR)) u_dec (
      .dev (start_dev_addr),
      .hit (dev_hit)
   );

   assign start_ack = start_valid & dev_hit;

   eeprom_tgt_ptr #(.AW(AW), .WA(WA)) u_ptr (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_hit  (start_ack),
      .start_miss (start_valid & ~dev_hit),
      .start_read (start_read),
      .start_dev  (start_dev_addr),
      .stop       (stop_valid),
      .wr         (wr_valid),
      .wr_data    (wr_data),
      .rd         (rd_valid),
      .ptr_q      (ptr_q),
      .active_q   (active_q),
      .rd_dir_q   (rd_dir_q),
      .wr_take    (wr_take),
      .data_phase (data_phase),
      .rd_take    (rd_take)
   );

   assign wr_ack = wr_take;
   assign bus_we = wr_take & data_phase & write_en;

   eeprom_tgt_mem #(.AW(AW)) u_mem (
      .clk      (clk),
      .rst_n    (rst_n),
      .bd_we    (bd_we),
      .bd_addr  (bd_addr),
      .bd_data  (bd_data),
      .bus_we   (bus_we),
      .bus_addr (ptr_q),
      .bus_data (wr_data),
      .rd_en    (rd_take),
      .rd_addr  (ptr_q),
      .rd_q     (rd_data)
   );

endmodule

// File: rtl/eeprom_tgt_chk.sv
module eeprom_tgt_chk
   import eeprom_tgt_pkg::*;
#(
   parameter int         MEM_BYTES = 512,
   parameter logic [6:0] DEV_ADDR  = 7'h51,
   localparam int        AW        = $clog2(MEM_BYTES)
) (
   input logic          clk,
   input logic          rst_n,
   input logic          start_valid,
   input logic [6:0]    start_dev_addr,
   input logic          start_ack,
   input logic          wr_valid,
   input logic          wr_ack,
   input logic          rd_valid,
   input logic [7:0]    rd_data,
   input logic          stop_valid,
   input logic [AW-1:0] ptr,
   input logic          active,
   input logic          rd_dir
);
   localparam int WA      = word_addr_bits(MEM_BYTES);
   localparam int DEV_LOW = (AW > WA) ? (AW - WA) : 0;
   localparam int RUN     = 1 << DEV_LOW;
   localparam int BASE    = (int'(DEV_ADDR) / RUN) * RUN;
   localparam logic [AW-1:0] LAST = '1;

   logic in_run;
   assign in_run = (int'(start_dev_addr) >= BASE) && (int'(start_dev_addr) < BASE + RUN);

   p_decode_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
      start_valid |-> (start_ack == in_run));

   p_read_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && active && !start_valid && !stop_valid && !wr_valid) |=>
      (ptr == $past(ptr) + 1'b1));

   p_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && active && ptr == LAST && !start_valid && !stop_valid && !wr_valid) |=>
      (ptr == '0));

   p_restart_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (start_ack && active) |=> (ptr == $past(ptr)));

   p_read_dir_nack_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && active && rd_dir) |-> !wr_ack);

   p_stop_closes_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_valid && !start_valid) |=> !active);

   p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!active && !start_valid) |=> ($stable(rd_data) && $stable(ptr)));

endmodule

bind serial_eeprom_target eeprom_tgt_chk #(.MEM_BYTES(MEM_BYTES), .DEV_ADDR(DEV_ADDR)) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .start_valid    (start_valid),
   .start_dev_addr (start_dev_addr),
   .start_ack      (start_ack),
   .wr_valid       (wr_valid),
   .wr_ack         (wr_ack),
   .rd_valid       (rd_valid),
   .rd_data        (rd_data),
   .stop_valid     (stop_valid),
   .ptr            (ptr_q),
   .active         (active_q),
   .rd_dir         (rd_dir_q)
);

// File: tb/serial_eeprom_target_tb.sv
module serial_eeprom_target_tb;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic write_en = 1'b1;
   logic start_valid = 1'b0, start_read = 1'b0;
   logic [6:0] start_dev_addr = 7'd0;
   logic wr_valid = 1'b0, rd_valid = 1'b0, stop_valid = 1'b0;
   logic [7:0] wr_data = 8'd0;
   logic bd_we = 1'b0;
   logic [11:0] bd_addr = 12'd0;
   logic [7:0] bd_data = 8'd0;

   logic start_ack0, wr_ack0, start_ack1, wr_ack1;
   logic [7:0] rd_data0, rd_data1;

   int checks = 0;
   int fails  = 0;

   always #10 clk = ~clk;

   // 512-byte array: 8-bit word address, answers device addresses 0x50 and 0x51
   serial_eeprom_target #(.MEM_BYTES(512), .DEV_ADDR(7'h51)) u_dut (
      .clk(clk), .rst_n(rst_n), .write_en(write_en),
      .start_valid(start_valid), .start_dev_addr(start_dev_addr), .start_read(start_read),
      .start_ack(start_ack0), .wr_valid(wr_valid), .wr_data(wr_data), .wr_ack(wr_ack0),
      .rd_valid(rd_valid), .rd_data(rd_data0), .stop_valid(stop_valid),
      .bd_we(bd_we), .bd_addr(bd_addr[8:0]), .bd_data(bd_data)
   );

   // 4096-byte array: 16-bit word address, answers device address 0x20 only
   serial_eeprom_target #(.MEM_BYTES(4096), .DEV_ADDR(7'h20)) u_dut16 (
      .clk(clk), .rst_n(rst_n), .write_en(write_en),
      .start_valid(start_valid), .start_dev_addr(start_dev_addr), .start_read(start_read),
      .start_ack(start_ack1), .wr_valid(wr_valid), .wr_data(wr_data), .wr_ack(wr_ack1),
      .rd_valid(rd_valid), .rd_data(rd_data1), .stop_valid(stop_valid),
      .bd_we(bd_we), .bd_addr(bd_addr), .bd_data(bd_data)
   );

   function automatic logic [7:0] pre(input int a);
      return 8'((a * 7 + 3) & 255);
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic op_start(input logic [6:0] dev, input bit rd, input bit e0, input bit e1,
                           input string req);
      @(negedge clk);
      start_valid = 1'b1; start_dev_addr = dev; start_read = rd;
      #1;
      chk(start_ack0 == e0, req, start_ack0, e0);
      chk(start_ack1 == e1, req, start_ack1, e1);
      @(posedge clk); #1;
      start_valid = 1'b0; bd_we = 1'b0;
   endtask

   task automatic op_write(input logic [7:0] d, input bit e0, input bit e1, input string req);
      @(negedge clk);
      wr_valid = 1'b1; wr_data = d;
      #1;
      chk(wr_ack0 == e0, req, wr_ack0, e0);
      chk(wr_ack1 == e1, req, wr_ack1, e1);
      @(posedge clk); #1;
      wr_valid = 1'b0; bd_we = 1'b0;
   endtask

   task automatic op_read(input bit which, input logic [7:0] exp, input string req);
      @(negedge clk);
      rd_valid = 1'b1;
      @(posedge clk); #1;
      rd_valid = 1'b0; bd_we = 1'b0;
      if (which) chk(rd_data1 == exp, req, rd_data1, exp);
      else       chk(rd_data0 == exp, req, rd_data0, exp);
   endtask

   task automatic op_stop();
      @(negedge clk);
      stop_valid = 1'b1;
      @(posedge clk); #1;
      stop_valid = 1'b0;
   endtask

   task automatic bd_write(input int a, input logic [7:0] d);
      @(negedge clk);
      bd_we = 1'b1; bd_addr = 12'(a); bd_data = d;
      @(posedge clk); #1;
      bd_we = 1'b0;
   endtask

   task automatic t_reset();
      chk(rd_data0 == 8'd0, "R6 reset rd_data", rd_data0, 0);
      chk(rd_data1 == 8'd0, "R6 reset rd_data (16-bit)", rd_data1, 0);
   endtask

   task automatic t_decode();
      op_start(7'h52, 1'b0, 1'b0, 1'b0, "R2 above run refused");
      op_start(7'h4F, 1'b0, 1'b0, 1'b0, "R2 below run refused");
      op_write(8'h00, 1'b0, 1'b0, "R2 refused start opens nothing");
      op_start(7'h51, 1'b0, 1'b1, 1'b0, "R2 upper address in run");
      op_stop();
      op_start(7'h50, 1'b0, 1'b1, 1'b0, "R2 base address in run");
      op_stop();
   endtask

   task automatic t_idle_read();
      op_start(7'h51, 1'b1, 1'b1, 1'b0, "R3 read start from idle");
      op_read(1'b0, pre(256), "R3 pointer loads device bit as bit 8");
      op_read(1'b0, pre(257), "R6 sequential read");
      op_stop();
   endtask

   task automatic t_write_seq();
      op_start(7'h50, 1'b0, 1'b1, 1'b0, "R4 write start");
      op_write(8'h10, 1'b1, 1'b0, "R4 address byte acked");
      op_write(8'hAA, 1'b1, 1'b0, "R5 data byte acked");
      op_write(8'hBB, 1'b1, 1'b0, "R5 second data byte acked");
      op_stop();
      op_start(7'h50, 1'b0, 1'b1, 1'b0, "R4 write start");
      op_write(8'h10, 1'b1, 1'b0, "R4 address byte");
      op_start(7'h50, 1'b1, 1'b1, 1'b0, "R8 repeated start");
      op_read(1'b0, 8'hAA, "R8 read continues at written address");
      op_read(1'b0, 8'hBB, "R5 second byte stored");
      op_stop();
      op_start(7'h51, 1'b0, 1'b1, 1'b0, "R1 upper bank start");
      op_write(8'h10, 1'b1, 1'b0, "R1 address byte");
      op_start(7'h51, 1'b1, 1'b1, 1'b0, "R8 repeated start");
      op_read(1'b0, pre(272), "R1 device bit selects upper bank");
      op_stop();
   endtask

   task automatic t_write_blocked();
      write_en = 1'b0;
      op_start(7'h50, 1'b0, 1'b1, 1'b0, "R5 start");
      op_write(8'h20, 1'b1, 1'b0, "R4 address byte");
      op_write(8'h77, 1'b1, 1'b0, "R5 blocked byte still acked");
      op_write(8'h78, 1'b1, 1'b0, "R5 blocked byte still acked");
      op_start(7'h50, 1'b1, 1'b1, 1'b0, "R8 repeated start");
      op_read(1'b0, pre(34), "R5 pointer advanced past blocked bytes");
      op_stop();
      write_en = 1'b1;
      op_start(7'h50, 1'b0, 1'b1, 1'b0, "R5 start");
      op_write(8'h20, 1'b1, 1'b0, "R4 address byte");
      op_start(7'h50, 1'b1, 1'b1, 1'b0, "R8 repeated start");
      op_read(1'b0, pre(32), "R5 blocked byte not stored");
      op_read(1'b0, pre(33), "R5 blocked byte not stored");
      op_stop();
   endtask

   task automatic t_wrap();
      op_start(7'h51, 1'b0, 1'b1, 1'b0, "R7 start");
      op_write(8'hFF, 1'b1, 1'b0, "R7 address byte");
      op_start(7'h51, 1'b1, 1'b1, 1'b0, "R8 repeated start");
      op_read(1'b0, pre(511), "R7 last location");
      op_read(1'b0, pre(0), "R7 wraps to location 0");
      op_stop();
   endtask

   task automatic t_read_dir_write();
      op_start(7'h50, 1'b1, 1'b1, 1'b0, "R9 read start");
      op_write(8'h33, 1'b0, 1'b0, "R9 write in read transfer refused");
      op_read(1'b0, pre(0), "R9 pointer untouched by refused byte");
      op_stop();
      op_write(8'h44, 1'b0, 1'b0, "R10 write after stop refused");
      op_read(1'b0, pre(0), "R10 read after stop holds rd_data");
   endtask

   task automatic t_collide();
      op_start(7'h50, 1'b0, 1'b1, 1'b0, "R11 start");
      op_write(8'h30, 1'b1, 1'b0, "R11 address byte");
      bd_addr = 12'h030; bd_data = 8'h3C; bd_we = 1'b1;
      op_write(8'hC3, 1'b1, 1'b0, "R11 colliding bus write acked");
      op_start(7'h50, 1'b0, 1'b1, 1'b0, "R8 restart for address");
      op_write(8'h30, 1'b1, 1'b0, "R8 new address after restart");
      op_start(7'h50, 1'b1, 1'b1, 1'b0, "R8 repeated start");
      op_read(1'b0, 8'hC3, "R11 bus write wins collision");
      bd_addr = 12'h031; bd_data = 8'h99; bd_we = 1'b1;
      op_read(1'b0, pre(49), "R11 colliding read returns old byte");
      op_start(7'h50, 1'b0, 1'b1, 1'b0, "R11 restart");
      op_write(8'h31, 1'b1, 1'b0, "R11 address byte");
      op_start(7'h50, 1'b1, 1'b1, 1'b0, "R8 repeated start");
      op_read(1'b0, 8'h99, "R11 preload landed");
      op_stop();
   endtask

   task automatic t_wide_addr();
      bd_write(12'hFFE, 8'h5E);
      bd_write(12'hFFF, 8'h6F);
      op_start(7'h20, 1'b0, 1'b0, 1'b1, "R2 16-bit instance start");
      op_write(8'hFF, 1'b0, 1'b1, "R1 high address byte");
      op_write(8'hFE, 1'b0, 1'b1, "R1 low address byte");
      op_start(7'h20, 1'b1, 1'b0, 1'b1, "R8 repeated start");
      op_read(1'b1, 8'h5E, "R1 two address bytes, excess bits dropped");
      op_read(1'b1, 8'h6F, "R6 sequential read 16-bit");
      op_read(1'b1, pre(0), "R7 wrap 16-bit instance");
      op_start(7'h21, 1'b0, 1'b0, 1'b0, "R2 single address run");
      op_read(1'b1, pre(0), "R2 refused start closes transfer");
      op_stop();
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      t_reset();
      for (int a = 0; a < 512; a++) bd_write(a, pre(a));
      t_decode();
      t_idle_read();
      t_write_seq();
      t_write_blocked();
      t_wrap();
      t_read_dir_write();
      t_collide();
      t_wide_addr();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule